// File: doc/BRIEF.md
# Triggered Clock Burst Generator

This block drives a serial clock pin with bursts of exactly eight pulses, each burst started by a low-to-high transition on a trigger input. The same trigger line also selects the rate of the burst: a fixed number of system cycles after the edge is found, the line is sampled again. If it is still high, the burst runs at the fast rate. If it has already dropped, the burst runs at the slow rate. Both rates come from even integer dividers of the system clock, and the default dividers are 4:1 apart. The clock output idles low, and each pulse is high for half of its period.

A host controls the block through a three-bit function code with a ready handshake. A code of zero means ready. Codes 1 to 3 (initialize, drive the clock pin, release the clock pin) are carried out in one cycle, and the code then returns to zero to signal completion. Code 4 enters pulse mode. In this mode the block re-arms after every burst and keeps the code at 4. To leave pulse mode, the host raises a stop request. The block stays in pulse mode until the next trigger edge, answers that edge with one dummy burst at the fast rate, and then returns to ready.

Top module: `trig_burst_gen`

## Requirements
- R1: After reset, the function code reads 0, ready is high, the clock output is low and the output enable is low.
- R2: A command is taken only while ready is high. Codes 1, 2 and 3 show on the function code one cycle after the command edge and clear to 0 on the following edge. Code 4 stays on the function code for as long as pulse mode lasts.
- R3: Code 2 raises the output enable. Code 3 lowers it. Code 1 (initialize) also lowers it.
- R4: A command issued while the function code is nonzero has no effect. Code values 5, 6 and 7 are never taken.
- R5: In pulse mode, each rising edge of the trigger input (after a two-flop synchronizer) produces exactly 8 high pulses on the clock output.
- R6: The synchronized trigger level is taken SAMPLE_DLY cycles after the edge is detected. A high level gives pulses of FAST_DIV system cycles, high for FAST_DIV/2 of them. A low level gives pulses of SLOW_DIV cycles, high for SLOW_DIV/2.
- R7: The clock output is low whenever no burst is running.
- R8: Trigger edges that arrive during a burst, or while the level is being sampled, start no burst. After each burst the block re-arms for the next edge.
- R9: A stop request in pulse mode is latched. The next trigger edge then gives one 8-pulse burst at the fast rate whatever the line level, after which the function code returns to 0.
- R10: A stop request outside pulse mode is ignored: a later pulse mode does not exit on its first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Function code offered with the strobe |
| stopReq | input | 1 | Request to leave pulse mode |
| trigIn | input | 1 | Asynchronous trigger and rate-select line |
| funcCode | output | 3 | Current function code, 0 when ready |
| ready | output | 1 | High when the function code is 0 |
| sclkOut | output | 1 | Serial clock value |
| sclkOe | output | 1 | Output enable for the clock pin |

## Verification
A corrupted burst counter shows up within the burst as a seventh or ninth pulse. A wrong rate latch shows up as a wrong pulse width on the very first pulse. A control state stuck outside the armed state shows up as a missing burst one trigger later. If the stop latch is set or cleared at the wrong time, the block either leaves pulse mode on the wrong edge or reports ready late, and the function code reveals this at the end of the next burst. Output-enable faults are visible two cycles after the command that should have changed it.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  typedef enum logic [2:0] {
    FC_READY = 3'd0,
    FC_INIT  = 3'd1,
    FC_DRIVE = 3'd2,
    FC_FLOAT = 3'd3,
    FC_PULSE = 3'd4
  } funcCode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_ARMED,
    ST_SETTLE,
    ST_BURST
  } ctrlState_e;

  typedef struct packed {
    logic start;
    logic fast;
  } burstCmd_t;

  localparam int PULSES_PER_BURST = 8;
endpackage

// File: rtl/tbg_datapath.sv
module tbg_datapath
  import tbg_pkg::*;
#(
  parameter int FAST_DIV    = 2,
  parameter int SLOW_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      trigIn,
  input  burstCmd_t bcmd,
  output logic      trigRise,
  output logic      trigLevel,
  output logic      burstOn,
  output logic      burstDone,
  output logic      sclkOut
);
  localparam int FAST_HALF = FAST_DIV / 2;
  localparam int SLOW_HALF = SLOW_DIV / 2;
  localparam int HW        = $clog2(SLOW_HALF + 1);
  localparam int EDGES     = 2 * PULSES_PER_BURST;
  localparam int EW        = $clog2(EDGES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   trigPrev;
  logic                   fastSel;
  logic [HW-1:0]          halfCnt;
  logic [EW-1:0]          edgeCnt;
  logic                   lastHalf;

  // synchronizer chain; one stage per generate step
  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= trigIn;
  end
  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[i] <= 1'b0;
      else       syncQ[i] <= syncQ[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= syncQ[SYNC_STAGES-1];
  end

  assign trigLevel = syncQ[SYNC_STAGES-1];
  assign trigRise  = trigLevel & ~trigPrev;

  assign lastHalf  = fastSel ? (halfCnt == HW'(FAST_HALF - 1))
                             : (halfCnt == HW'(SLOW_HALF - 1));
  assign burstDone = burstOn && lastHalf && (edgeCnt == EW'(EDGES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstOn <= 1'b0;
      fastSel <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      sclkOut <= 1'b0;
    end else if (bcmd.start) begin
      burstOn <= 1'b1;
      fastSel <= bcmd.fast;
      halfCnt <= '0;
      edgeCnt <= '0;
      sclkOut <= 1'b0;
    end else if (burstOn) begin
      if (lastHalf) begin
        halfCnt <= '0;
        edgeCnt <= edgeCnt + 1'b1;
        sclkOut <= ~sclkOut;
        if (burstDone) burstOn <= 1'b0;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // R7: the clock rests low outside a burst
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !burstOn |-> !sclkOut);
  // R5: the last edge of a burst is a falling one
  p_last_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !sclkOut && !burstOn);
endmodule

// File: rtl/tbg_ctrl.sv
module tbg_ctrl
  import tbg_pkg::*;
#(
  parameter int SAMPLE_DLY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       stopReq,
  input  logic       trigRise,
  input  logic       trigLevel,
  input  logic       burstOn,
  input  logic       burstDone,
  output burstCmd_t  bcmd,
  output logic [2:0] funcCode,
  output logic       sclkOe
);
  localparam int DW = $clog2(SAMPLE_DLY) + 1;

  ctrlState_e     state;
  logic [DW-1:0]  settleCnt;
  logic           stopLatched;
  logic           exitPending;
  logic           settleDone;
  logic           cmdLegal;

  assign cmdLegal   = (cmdCode != FC_READY) && (cmdCode <= FC_PULSE);
  assign settleDone = (state == ST_SETTLE) && (settleCnt == DW'(SAMPLE_DLY - 1));
  assign bcmd.start = settleDone;
  assign bcmd.fast  = trigLevel | stopLatched;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      funcCode    <= FC_READY;
      sclkOe      <= 1'b0;
      settleCnt   <= '0;
      stopLatched <= 1'b0;
      exitPending <= 1'b0;
    end else begin
      if (stopReq && funcCode == FC_PULSE) stopLatched <= 1'b1;
      unique case (state)
        ST_IDLE: if (cmdValid && cmdLegal) begin
          funcCode <= cmdCode;
          state    <= (cmdCode == FC_PULSE) ? ST_ARMED : ST_EXEC;
        end
        ST_EXEC: begin
          if (funcCode == FC_DRIVE) sclkOe <= 1'b1;
          else                      sclkOe <= 1'b0;
          funcCode <= FC_READY;
          state    <= ST_IDLE;
        end
        ST_ARMED: if (trigRise) begin
          settleCnt <= '0;
          state     <= ST_SETTLE;
        end
        ST_SETTLE: begin
          settleCnt <= settleCnt + 1'b1;
          if (settleDone) begin
            exitPending <= stopLatched;
            state       <= ST_BURST;
          end
        end
        ST_BURST: if (burstDone) begin
          if (exitPending) begin
            funcCode    <= FC_READY;
            stopLatched <= 1'b0;
            exitPending <= 1'b0;
            state       <= ST_IDLE;
          end else begin
            state <= ST_ARMED;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: only defined codes ever appear
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    funcCode <= FC_PULSE);
  // R2: one-cycle commands complete on the next edge
  p_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    (funcCode inside {FC_INIT, FC_DRIVE, FC_FLOAT}) |=> funcCode == FC_READY);
  // R4: the pin driver is untouched while pulse mode runs
  p_oe_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (funcCode == FC_PULSE) |=> $stable(sclkOe));
  // R8: a burst never starts over a running one
  p_start_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    bcmd.start |-> !burstOn);
endmodule

// File: rtl/trig_burst_gen.sv
module trig_burst_gen
  import tbg_pkg::*;
#(
  parameter int FAST_DIV    = 2,
  parameter int SLOW_DIV    = 8,
  parameter int SAMPLE_DLY  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       stopReq,
  input  logic       trigIn,
  output logic [2:0] funcCode,
  output logic       ready,
  output logic       sclkOut,
  output logic       sclkOe
);
  burstCmd_t bcmd;
  logic      trigRise;
  logic      trigLevel;
  logic      burstOn;
  logic      burstDone;

  tbg_ctrl #(.SAMPLE_DLY(SAMPLE_DLY)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .stopReq(stopReq), .trigRise(trigRise), .trigLevel(trigLevel),
    .burstOn(burstOn), .burstDone(burstDone), .bcmd(bcmd),
    .funcCode(funcCode), .sclkOe(sclkOe)
  );

  tbg_datapath #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .bcmd(bcmd),
    .trigRise(trigRise), .trigLevel(trigLevel), .burstOn(burstOn),
    .burstDone(burstDone), .sclkOut(sclkOut)
  );

  assign ready = (funcCode == FC_READY);
endmodule

// File: tb/trig_burst_gen_test.sv
module trig_burst_gen_test;
  localparam int FAST_DIV = 2;
  localparam int SLOW_DIV = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic       stopReq = 1'b0;
  logic       trigIn = 1'b0;
  logic [2:0] funcCode;
  logic       ready;
  logic       sclkOut;
  logic       sclkOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // expected burst rate per burst: 1 = fast, 0 = slow
  bit expQ[$];

  // monitor state
  bit prevS = 1'b0;
  int highRun = 0;
  int pulseIdx = 0;
  int widths[8];

  trig_burst_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .stopReq(stopReq), .trigIn(trigIn), .funcCode(funcCode), .ready(ready),
    .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // monitor: measures each high pulse at negedges, scores 8-pulse groups
  always @(negedge clk) begin
    if (rstN) begin
      if (sclkOut) highRun++;
      if (prevS && !sclkOut) begin
        widths[pulseIdx] = highRun;
        highRun = 0;
        pulseIdx++;
        if (pulseIdx == 8) begin
          bit fastExp;
          int wantW;
          int badW;
          pulseIdx = 0;
          if (expQ.size() == 0) begin
            check(1'b0, "R5/R8 unexpected burst", 1, 0);
          end else begin
            fastExp = expQ.pop_front();
            wantW = fastExp ? FAST_DIV / 2 : SLOW_DIV / 2;
            badW = -1;
            foreach (widths[k]) if (widths[k] != wantW) badW = widths[k];
            check(badW == -1, "R6/R9 pulse width", badW, wantW);
          end
        end
      end
      prevS = sclkOut;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [2:0] code);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code;
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 3'd0;
  endtask

  // driver: records expected rate then fires the trigger
  task automatic fire(input bit fast, input bit expectBurst, input bit expRate);
    if (expectBurst) expQ.push_back(expRate);
    @(negedge clk);
    trigIn = 1'b1;
    if (fast) cycles(20);
    else      cycles(1);
    trigIn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    cycles(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(funcCode == 3'd0, "R1 funcCode", funcCode, 0);
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(sclkOut == 1'b0, "R1 sclkOut", sclkOut, 0);
    check(sclkOe == 1'b0, "R1 sclkOe", sclkOe, 0);

    // R4 illegal codes ignored
    for (int c = 5; c < 8; c++) begin
      sendCmd(3'(c));
      check(funcCode == 3'd0, "R4 illegal code", funcCode, 0);
    end

    // R2, R3 drive command
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 3'd2;
    @(negedge clk);
    cmdValid = 1'b0;
    check(funcCode == 3'd2, "R2 code visible", funcCode, 2);
    @(negedge clk);
    check(ready == 1'b1, "R2 done", ready, 1);
    check(sclkOe == 1'b1, "R3 drive", sclkOe, 1);
    sendCmd(3'd3); cycles(1);
    check(sclkOe == 1'b0, "R3 float", sclkOe, 0);
    sendCmd(3'd2); cycles(1);
    sendCmd(3'd1); cycles(1);
    check(sclkOe == 1'b0, "R3 init", sclkOe, 0);
    check(funcCode == 3'd0, "R2 init done", funcCode, 0);
    sendCmd(3'd2); cycles(1);

    // R10 stop outside pulse mode ignored
    @(negedge clk); stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    sendCmd(3'd4);
    check(funcCode == 3'd4, "R2 pulse mode", funcCode, 4);
    fire(1'b0, 1'b1, 1'b0); cycles(100);
    check(funcCode == 3'd4, "R10 stays in pulse mode", funcCode, 4);

    // R4 command while busy ignored
    sendCmd(3'd3); cycles(2);
    check(sclkOe == 1'b1, "R4 busy cmd oe", sclkOe, 1);
    check(funcCode == 3'd4, "R4 busy cmd code", funcCode, 4);

    // R5, R6 rates
    fire(1'b1, 1'b1, 1'b1); cycles(60);
    check(sclkOut == 1'b0, "R7 idle low", sclkOut, 0);
    fire(1'b0, 1'b1, 1'b0); cycles(100);
    check(sclkOut == 1'b0, "R7 idle low slow", sclkOut, 0);

    // R8 edge during burst ignored, then re-arm
    fire(1'b0, 1'b1, 1'b0); cycles(30);
    fire(1'b0, 1'b0, 1'b0); cycles(100);
    fire(1'b1, 1'b1, 1'b1); cycles(60);

    // R9 stop then dummy fast burst with low line
    @(negedge clk); stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    check(funcCode == 3'd4, "R9 waits for edge", funcCode, 4);
    fire(1'b0, 1'b1, 1'b1); cycles(60);
    check(funcCode == 3'd0, "R9 exit code", funcCode, 0);
    check(ready == 1'b1, "R9 ready", ready, 1);

    // no burst after exit
    fire(1'b1, 1'b0, 1'b0); cycles(60);
    check(expQ.size() == 0, "R5 bursts missing", expQ.size(), 0);
    check(pulseIdx == 0, "R5 partial burst", pulseIdx, 0);
    summary();
  end
endmodule